// File: doc/BRIEF.md
# Flicker Perception Stage

This block turns a stream of signed voltage samples into an instantaneous flicker sensation value. Each sample's magnitude is divided by a slowly tracking reference taken from half-cycle RMS figures, and the quotient is squared to mimic how a filament lamp's light follows the square of its supply. A first-order high-pass then strips the steady part. The resulting band signal leaves the block on a send port so that an external chain can apply the 35 Hz band limit and the eye-response weighting. The weighted value comes back on a return port. There it is squared and averaged by a first-order low-pass that stands in for the short memory of visual perception.

The reference filter has a time constant of 27.3 s. The high-pass corner sits at 0.05 Hz and the smoothing constant is 300 ms. All three filters are built as `y = y + ((x - y) >>> k)`. Each shift `k` is the ceiling base-2 logarithm of the time constant multiplied by the rate at which that filter is updated, and is derived from the sample rate and mains frequency parameters. With the defaults (10240 samples/s, 50 Hz mains, so 100 RMS strobes/s), the reference shift is 12, the high-pass shift 15 and the smoothing shift 12.

The division is restoring and bit-serial, one quotient bit per clock. Samples that arrive while a division is running wait in a short queue.

Top module: `flicker_perception`

## Requirements
- R1: While reset is held, and on the first cycle after it, `notReady` is 1, `flkData` is 0, and `wtOutValid` and `flkValid` are 0.
- R2: The first `rmsValid` after reset loads the reference state `ref = rms*256`. Every later strobe applies `ref += ((rms*256) - ref) >>> 12`. `notReady` falls on the cycle after the first strobe and then stays low until reset.
- R3: While `notReady` is 1, samples and weighting returns are ignored: no `wtOutValid` pulse appears, no `flkValid` pulse appears and `flkData` stays 0.
- R4: A sample is accepted only when the block is ready. For each accepted sample, the divisor is `d = max(1, ref >>> 8)`, taken from the reference as it stood before any RMS strobe arriving in the same cycle. The normalised magnitude is `q = min(floor(|s| * 16384 / d), 131071)`.
- R5: The lamp stage output is `x = floor(q*q / 16384)`.
- R6: For each processed sample, in arrival order, a high-pass state is updated as `lp += ((x*256) - lp) >>> 15`. The send value is then `hp = x - (lp >>> 8)`, computed with the updated `lp`. It appears on `wtOutData` during a single-cycle `wtOutValid` pulse.
- R7: Up to 4 samples can wait while another one is being divided. A sample that arrives while the queue is full is dropped and produces no send pulse.
- R8: Each weighting return `w` is converted to `p = min(floor(w*w / 16384), 2^31 - 1)`.
- R9: A return that arrives while the block is ready updates `flk += (p - flk) >>> 12`. On the next cycle `flkValid` pulses and `flkData` shows the updated value. At all other times `flkData` holds its value.
- R10: `flkData` is never negative.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | Sample strobe |
| sampleData | input | 16 | Signed voltage sample |
| rmsValid | input | 1 | Half-cycle RMS strobe |
| rmsData | input | 16 | Unsigned half-cycle RMS value |
| wtOutValid | output | 1 | High-passed value ready for the weighting chain |
| wtOutData | output | 23 | Signed high-passed lamp signal |
| wtInValid | input | 1 | Weighted value returned |
| wtInData | input | 24 | Signed weighted value |
| flkValid | output | 1 | New instantaneous flicker value |
| flkData | output | 32 | Instantaneous flicker value |
| notReady | output | 1 | No reference loaded yet |

## Verification
The assertions assume that the external weighting chain never returns more than one value per clock and that a new sample never follows a finished one on the very next cycle. Under these assumptions, send pulses are single-cycle, and a flicker pulse can always be traced back to a return one cycle earlier. The stimulus spaces isolated samples by more than a full division and sends only one deliberate back-to-back burst, which exercises the queue limit. It drives returns at most one per cycle and independently of the send port. It covers a tiny reference that forces quotient saturation, return values large enough to hit the 32-bit limit, and an RMS strobe that coincides with a sample.

// File: rtl/flk_pkg.sv
package flk_pkg;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } flkStrobe_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RUN,
    S_FIN
  } divState_e;

endpackage

// File: rtl/flk_fifo.sv
module flk_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + AW'(1);
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + AW'(1);
      if (doPush && !doPop)      count <= count + CW'(1);
      else if (doPop && !doPush) count <= count - CW'(1);
    end
  end
endmodule

// File: rtl/flk_ctrl.sv
module flk_ctrl import flk_pkg::*; #(
  parameter int ITER = 30
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fifoEmpty,
  output flkStrobe_t strobe
);
  localparam int CW = $clog2(ITER + 1);

  divState_e     state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: if (!fifoEmpty) begin
          state <= S_RUN;
          cnt   <= CW'(ITER);
        end
        S_RUN: begin
          cnt <= cnt - CW'(1);
          if (cnt == CW'(1)) state <= S_FIN;
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load   = (state == S_IDLE) && !fifoEmpty;
    strobe.step   = (state == S_RUN);
    strobe.finish = (state == S_FIN);
  end
endmodule

// File: rtl/flk_datapath.sv
module flk_datapath import flk_pkg::*; #(
  parameter int SAMPLE_W     = 16,
  parameter int RMS_W        = 16,
  parameter int WT_W         = 24,
  parameter int FLK_W        = 32,
  parameter int FIFO_DEPTH   = 4,
  parameter int NORM_W       = 18,
  parameter int NORM_FRAC    = 14,
  parameter int REF_FRAC     = 8,
  parameter int HP_GUARD     = 8,
  parameter int REF_SHIFT    = 12,
  parameter int HP_SHIFT     = 15,
  parameter int SMOOTH_SHIFT = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  flkStrobe_t                 strobe,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] sampleData,
  input  logic                       rmsValid,
  input  logic [RMS_W-1:0]           rmsData,
  input  logic                       wtInValid,
  input  logic signed [WT_W-1:0]     wtInData,
  output logic                       fifoEmpty,
  output logic                       refLoaded,
  output logic                       wtOutValid,
  output logic signed [2*(NORM_W-1)-NORM_FRAC+2:0] wtOutData,
  output logic                       flkValid,
  output logic signed [FLK_W-1:0]    flkData
);
  localparam int DIV_N   = SAMPLE_W + NORM_FRAC;
  localparam int MAG_W   = NORM_W - 1;
  localparam int SQ_W    = 2 * MAG_W - NORM_FRAC + 2;
  localparam int HP_W    = SQ_W + 1;
  localparam int LP_W    = SQ_W + HP_GUARD + 1;
  localparam int REF_W   = RMS_W + REF_FRAC + 2;
  localparam int PROD_W  = 2 * WT_W;
  localparam int ENTRY_W = SAMPLE_W + RMS_W;
  localparam logic [MAG_W-1:0] MAG_MAX = '1;

  // ---------------- reference tracking ----------------
  logic signed [REF_W-1:0] refState, rmsScaled, refNext;
  logic signed [REF_W:0]   refDiff;
  logic                    refLoadedQ;
  logic [RMS_W-1:0]        refInt, divisorNow;

  assign rmsScaled = $signed({2'b00, rmsData, {REF_FRAC{1'b0}}});
  assign refDiff   = (REF_W+1)'(rmsScaled) - (REF_W+1)'(refState);
  assign refNext   = refState + REF_W'(refDiff >>> REF_SHIFT);
  assign refInt    = RMS_W'(refState >>> REF_FRAC);
  assign divisorNow = (refInt == '0) ? RMS_W'(1) : refInt;
  assign refLoaded = refLoadedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refState   <= '0;
      refLoadedQ <= 1'b0;
    end else if (rmsValid) begin
      refState   <= refLoadedQ ? refNext : rmsScaled;
      refLoadedQ <= 1'b1;
    end
  end

  // ---------------- sample queue ----------------
  logic [SAMPLE_W-1:0] magNow, headMag;
  logic [RMS_W-1:0]    headDiv;
  logic [ENTRY_W-1:0]  headEntry;
  logic                fifoFull;

  assign magNow = sampleData[SAMPLE_W-1] ? (~sampleData + SAMPLE_W'(1)) : sampleData;
  assign {headMag, headDiv} = headEntry;

  flk_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_queue (
    .clk   (clk),
    .rstN  (rstN),
    .push  (sampleValid && refLoadedQ),
    .pop   (strobe.load),
    .din   ({magNow, divisorNow}),
    .dout  (headEntry),
    .empty (fifoEmpty),
    .full  (fifoFull)
  );

  // ---------------- bit-serial restoring divider ----------------
  logic [RMS_W-1:0] remQ, divQ;
  logic [DIV_N-1:0] quoQ;
  logic [RMS_W:0]   remShift;
  logic             remFits;

  assign remShift = {remQ, quoQ[DIV_N-1]};
  assign remFits  = (remShift >= {1'b0, divQ});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remQ <= '0;
      quoQ <= '0;
      divQ <= '0;
    end else if (strobe.load) begin
      remQ <= '0;
      quoQ <= {headMag, {NORM_FRAC{1'b0}}};
      divQ <= headDiv;
    end else if (strobe.step) begin
      if (remFits) begin
        remQ <= RMS_W'(remShift - {1'b0, divQ});
        quoQ <= {quoQ[DIV_N-2:0], 1'b1};
      end else begin
        remQ <= RMS_W'(remShift);
        quoQ <= {quoQ[DIV_N-2:0], 1'b0};
      end
    end
  end

  // ---------------- lamp square ----------------
  logic [MAG_W-1:0]         qMag;
  logic [2*MAG_W-1:0]       sqFull;
  logic signed [SQ_W-1:0]   sqQ;
  logic                     sqValidQ;

  assign qMag   = (|quoQ[DIV_N-1:MAG_W]) ? MAG_MAX : quoQ[MAG_W-1:0];
  assign sqFull = {{MAG_W{1'b0}}, qMag} * {{MAG_W{1'b0}}, qMag};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sqQ      <= '0;
      sqValidQ <= 1'b0;
    end else begin
      sqValidQ <= strobe.finish;
      if (strobe.finish) sqQ <= SQ_W'(sqFull >> NORM_FRAC);
    end
  end

  // ---------------- DC removal ----------------
  logic signed [LP_W-1:0] lpQ, lpNext;
  logic signed [LP_W:0]   xScaled, lpDiff;
  logic signed [HP_W-1:0] hpVal;

  assign xScaled = (LP_W+1)'(sqQ) <<< HP_GUARD;
  assign lpDiff  = xScaled - (LP_W+1)'(lpQ);
  assign lpNext  = lpQ + LP_W'(lpDiff >>> HP_SHIFT);
  assign hpVal   = HP_W'(sqQ) - HP_W'(lpNext >>> HP_GUARD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lpQ        <= '0;
      wtOutData  <= '0;
      wtOutValid <= 1'b0;
    end else begin
      wtOutValid <= sqValidQ;
      if (sqValidQ) begin
        lpQ       <= lpNext;
        wtOutData <= hpVal;
      end
    end
  end

  // ---------------- perception square and smoothing ----------------
  logic signed [PROD_W-1:0] wSq, pShift;
  logic signed [FLK_W-1:0]  percept, flkNext;
  logic signed [FLK_W:0]    flkDiff;

  assign wSq    = PROD_W'(wtInData) * PROD_W'(wtInData);
  assign pShift = wSq >>> NORM_FRAC;

  always_comb begin
    if (|pShift[PROD_W-1:FLK_W-1]) percept = {1'b0, {(FLK_W-1){1'b1}}};
    else                           percept = pShift[FLK_W-1:0];
  end

  assign flkDiff = (FLK_W+1)'(percept) - (FLK_W+1)'(flkData);
  assign flkNext = flkData + FLK_W'(flkDiff >>> SMOOTH_SHIFT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flkData  <= '0;
      flkValid <= 1'b0;
    end else begin
      flkValid <= wtInValid && refLoadedQ;
      if (wtInValid && refLoadedQ) flkData <= flkNext;
    end
  end

  logic unusedFull;
  assign unusedFull = fifoFull;
endmodule

// File: rtl/flicker_perception.sv
module flicker_perception import flk_pkg::*; #(
  parameter int SAMPLE_W   = 16,
  parameter int RMS_W      = 16,
  parameter int WT_W       = 24,
  parameter int FLK_W      = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int NORM_W     = 18,
  parameter int NORM_FRAC  = 14,
  parameter int SAMPLE_HZ  = 10240,
  parameter int LINE_HZ    = 50
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] sampleData,
  input  logic                       rmsValid,
  input  logic [RMS_W-1:0]           rmsData,
  output logic                       wtOutValid,
  output logic signed [2*(NORM_W-1)-NORM_FRAC+2:0] wtOutData,
  input  logic                       wtInValid,
  input  logic signed [WT_W-1:0]     wtInData,
  output logic                       flkValid,
  output logic signed [FLK_W-1:0]    flkData,
  output logic                       notReady
);
  // shift = ceil(log2(time constant * update rate))
  localparam int REF_SHIFT    = $clog2((273 * 2 * LINE_HZ) / 10);
  localparam int HP_SHIFT     = $clog2((SAMPLE_HZ * 1000) / 314);
  localparam int SMOOTH_SHIFT = $clog2((SAMPLE_HZ * 3) / 10);
  localparam int DIV_ITER     = SAMPLE_W + NORM_FRAC;

  flkStrobe_t strobe;
  logic       fifoEmpty, refLoaded;

  flk_ctrl #(.ITER(DIV_ITER)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fifoEmpty (fifoEmpty),
    .strobe    (strobe)
  );

  flk_datapath #(
    .SAMPLE_W     (SAMPLE_W),
    .RMS_W        (RMS_W),
    .WT_W         (WT_W),
    .FLK_W        (FLK_W),
    .FIFO_DEPTH   (FIFO_DEPTH),
    .NORM_W       (NORM_W),
    .NORM_FRAC    (NORM_FRAC),
    .REF_FRAC     (8),
    .HP_GUARD     (8),
    .REF_SHIFT    (REF_SHIFT),
    .HP_SHIFT     (HP_SHIFT),
    .SMOOTH_SHIFT (SMOOTH_SHIFT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .sampleValid (sampleValid),
    .sampleData  (sampleData),
    .rmsValid    (rmsValid),
    .rmsData     (rmsData),
    .wtInValid   (wtInValid),
    .wtInData    (wtInData),
    .fifoEmpty   (fifoEmpty),
    .refLoaded   (refLoaded),
    .wtOutValid  (wtOutValid),
    .wtOutData   (wtOutData),
    .flkValid    (flkValid),
    .flkData     (flkData)
  );

  assign notReady = !refLoaded;
endmodule

// File: rtl/flk_checker.sv
module flk_checker #(
  parameter int FLK_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             rmsValid,
  input logic             wtInValid,
  input logic             wtOutValid,
  input logic             flkValid,
  input logic [FLK_W-1:0] flkData,
  input logic             notReady
);
  a_r1_reset_state: assert property (@(posedge clk)
    !rstN |=> (notReady && !flkValid && !wtOutValid && flkData == '0));

  a_r2_ready_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !notReady |=> !notReady);

  a_r2_ready_from_rms: assert property (@(posedge clk) disable iff (!rstN)
    $fell(notReady) |-> $past(rmsValid));

  a_r3_silent_until_ready: assert property (@(posedge clk) disable iff (!rstN)
    notReady |-> (flkData == '0 && !flkValid && !wtOutValid));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wtOutValid |=> !wtOutValid);

  a_r9_flk_follows_return: assert property (@(posedge clk) disable iff (!rstN)
    flkValid |-> $past(wtInValid));

  a_r9_return_gives_flk: assert property (@(posedge clk) disable iff (!rstN)
    (wtInValid && !notReady) |=> flkValid);

  a_r9_flk_held: assert property (@(posedge clk) disable iff (!rstN)
    !flkValid |-> $stable(flkData));

  a_r10_non_negative: assert property (@(posedge clk) disable iff (!rstN)
    !flkData[FLK_W-1]);
endmodule

bind flicker_perception flk_checker #(.FLK_W(FLK_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rmsValid   (rmsValid),
  .wtInValid  (wtInValid),
  .wtOutValid (wtOutValid),
  .flkValid   (flkValid),
  .flkData    (flkData),
  .notReady   (notReady)
);

// File: tb/flicker_perception_test.sv
module flicker_perception_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic               sampleValid = 1'b0;
  logic signed [15:0] sampleData = '0;
  logic               rmsValid = 1'b0;
  logic [15:0]        rmsData = '0;
  logic               wtInValid = 1'b0;
  logic signed [23:0] wtInData = '0;
  logic               wtOutValid, flkValid, notReady;
  logic signed [22:0] wtOutData;
  logic signed [31:0] flkData;

  flicker_perception uut (
    .clk(clk), .rstN(rstN),
    .sampleValid(sampleValid), .sampleData(sampleData),
    .rmsValid(rmsValid), .rmsData(rmsData),
    .wtOutValid(wtOutValid), .wtOutData(wtOutData),
    .wtInValid(wtInValid), .wtInData(wtInData),
    .flkValid(flkValid), .flkData(flkData),
    .notReady(notReady)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // behavioural model state
  longint mRef = 0, mLp = 0, mFlk = 0;
  bit     mReady = 0;
  longint expWt[$];
  int     wtSeen = 0, flkSeen = 0, flkExp = 0;

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint lampOf(longint mag, longint refv);
    longint d = refv >>> 8;
    longint q;
    if (d < 1) d = 1;
    q = (mag <<< 14) / d;
    if (q > 131071) q = 131071;
    return (q * q) >>> 14;
  endfunction

  function automatic longint hpOf(longint x);
    mLp = mLp + (((x <<< 8) - mLp) >>> 15);
    return x - (mLp >>> 8);
  endfunction

  function automatic void flkUpdate(longint w);
    longint p = (w * w) >>> 14;
    if (p > 64'sd2147483647) p = 64'sd2147483647;
    mFlk = mFlk + ((p - mFlk) >>> 12);
  endfunction

  function automatic void refUpdate(longint r);
    if (!mReady) mRef = r <<< 8;
    else mRef = mRef + (((r <<< 8) - mRef) >>> 12);
    mReady = 1;
  endfunction

  function automatic longint absOf(longint v);
    return (v < 0) ? -v : v;
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R2/R3 notReady", longint'(notReady), longint'(!mReady));
      check("R9 flkData", longint'(flkData), mFlk);
      if (wtOutValid) begin
        wtSeen++;
        if (expWt.size() == 0) check("R3/R7 unexpected send pulse", 1, 0);
        else check("R4/R5/R6 send value", longint'(wtOutData), expWt.pop_front());
      end
      if (flkValid) flkSeen++;
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sendRms(int r);
    rmsValid = 1'b1; rmsData = 16'(r);
    tick(1);
    rmsValid = 1'b0;
    refUpdate(r);
  endtask

  task automatic sendSample(int s, bit keep);
    sampleValid = 1'b1; sampleData = 16'(s);
    if (mReady && keep) expWt.push_back(hpOf(lampOf(absOf(s), mRef)));
    tick(1);
    sampleValid = 1'b0;
  endtask

  task automatic sendBoth(int r, int s);
    rmsValid = 1'b1; rmsData = 16'(r);
    sampleValid = 1'b1; sampleData = 16'(s);
    if (mReady) expWt.push_back(hpOf(lampOf(absOf(s), mRef)));
    tick(1);
    rmsValid = 1'b0; sampleValid = 1'b0;
    refUpdate(r);
  endtask

  task automatic sendRet(int w);
    wtInValid = 1'b1; wtInData = 24'(w);
    tick(1);
    wtInValid = 1'b0;
    if (mReady) begin
      flkUpdate(w);
      flkExp++;
    end
  endtask

  task automatic resetCheck();
    check("R1 notReady", longint'(notReady), 1);
    check("R1 flkData", longint'(flkData), 0);
    check("R1 wtOutValid", longint'(wtOutValid), 0);
    check("R1 flkValid", longint'(flkValid), 0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    mReady = 0; mRef = 0; mLp = 0; mFlk = 0;
    expWt.delete();
    tick(2);
    resetCheck();
    rstN = 1'b1;
    tick(1);
    resetCheck();
  endtask

  initial begin
    tick(3);
    resetCheck();
    rstN = 1'b1;
    tick(1);
    resetCheck();

    // R3: nothing happens before a reference exists
    sendSample(500, 1);
    sendRet(1000);
    tick(50);
    check("R3 no send while not ready", wtSeen, 0);
    check("R3 no flicker while not ready", flkSeen, 0);

    // R4: tiny reference forces quotient saturation
    sendRms(3);
    sendSample(1000, 1);   tick(45);
    sendSample(-5, 1);     tick(45);
    sendSample(-32768, 1); tick(45);
    check("R6 all sends delivered", expWt.size(), 0);

    doReset();

    // R2/R4/R5/R6: nominal reference and several magnitudes
    sendRms(2000);
    sendSample(1000, 1);   tick(45);
    sendSample(-1500, 1);  tick(45);
    sendSample(0, 1);      tick(45);
    sendSample(32767, 1);  tick(45);
    sendSample(7, 1);      tick(45);

    // R2: reference tracking over many strobes
    for (int i = 0; i < 20; i++) begin
      sendRms(2600);
      tick(3);
    end
    sendSample(-2400, 1);  tick(45);

    // R4: strobe in the same cycle as a sample uses the old reference
    sendBoth(1200, 900);   tick(45);
    sendSample(900, 1);    tick(45);
    check("R6 sends delivered in order", expWt.size(), 0);

    // R7: back-to-back burst of 7, first 5 kept
    for (int i = 0; i < 7; i++) sendSample(3000 + 100 * i, (i < 5));
    tick(250);
    check("R7 queue keeps five of seven", expWt.size(), 0);

    // R8/R9: returns including saturating magnitudes
    sendRet(0);        tick(2);
    sendRet(1000);     tick(2);
    sendRet(-20000);   tick(2);
    sendRet(8000000);  tick(2);
    sendRet(-8388608); tick(2);
    for (int i = 0; i < 30; i++) begin
      sendRet(300000 - 5000 * i);
      tick(1);
    end
    sendRet(-1);
    sendRet(2);
    tick(5);
    check("R9 one pulse per return", flkSeen, flkExp);
    check("R10 flkData sign", longint'(flkData[31]), 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule